// File: doc/BRIEF.md
# Serial Transmit Queue and Character Framer

This block is the sending half of an asynchronous serial port. Bytes offered on a write strobe are held in a small first-in first-out queue. A framer takes them one at a time and shifts each out on a single line: a low start bit, then the data bits least significant first, an optional parity bit, and one or two high stop bits. The character size runs from five to eight bits and is picked by a two-bit code. Bit timing comes from a baud counter that divides the core clock by a programmable word plus one. The result is an oversample tick, and each bit on the line lasts sixteen of those ticks.

Software watches the queue through a live fill count. It also sees two status flags: one says the sender has fully drained, and one says the queue has dropped below a programmable threshold. Each flag has its own mask, and the masked flags are ORed into one interrupt line. Several control inputs act on the block. A break control pulls the line low for as long as it is held. An enable gates the start of new characters. A second enable stops the baud counter. A clear strobe throws away everything still queued.

Top module: `uart_tx_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the line `txd` is high (idle) if no break is requested, `fill_level` is 0 and `stat_empty` is 1.
- R2: Each write accepted into the queue raises `fill_level` by one, and each character start lowers it by one. A write made while `fill_level` equals DEPTH is dropped. Queued bytes are sent in the order they were written.
- R3: A `fifo_clr` pulse sets `fill_level` to 0 on the next cycle and no queued byte is sent afterwards. A write in the same cycle as the clear is also discarded.
- R4: A character is a low start bit followed by N data bits, least significant bit first, where `cfg_char_len` codes 0, 1, 2 and 3 give N = 5, 6, 7 and 8.
- R5: With `cfg_par_en` = 1 a parity bit follows the data. With `cfg_par_odd` = 0 the total number of ones in data plus parity is even. With `cfg_par_odd` = 1 that total is odd. With `cfg_par_en` = 0 no parity bit is sent.
- R6: `cfg_two_stop` = 0 sends one high stop bit and 1 sends two. Queued characters follow one another with no gap, so consecutive start edges are exactly (1 + N + P + S) bit periods apart.
- R7: One bit period lasts 16 × (`cfg_baud_word` + 1) clock cycles.
- R8: `stat_empty` is 1 exactly when the queue holds nothing and the last stop bit has finished. It rises one full frame length after the start edge of the last character.
- R9: `stat_below` is 1 exactly when `fill_level` < `cfg_thresh`.
- R10: `irq` = (`stat_empty` AND `irq_en_empty`) OR (`stat_below` AND `irq_en_below`).
- R11: While `cfg_break` is 1, `txd` is 0. When it is released, the line returns to the framer's level.
- R12: With `cfg_tx_en` = 0 no new character starts and the queue keeps its content. With `cfg_brg_en` = 0 the baud counter does not tick, so nothing starts or advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_clr | input | 1 | Discard all queued bytes |
| cfg_char_len | input | 2 | Character size code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Parity sense, 1 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_baud_word | input | DIV_W | Divisor minus one |
| cfg_brg_en | input | 1 | Baud counter enable |
| cfg_tx_en | input | 1 | Allow new characters to start |
| cfg_break | input | 1 | Force the line low |
| cfg_thresh | input | CNT_W | Below-threshold level |
| irq_en_empty | input | 1 | Mask for the drained status |
| irq_en_below | input | 1 | Mask for the below-threshold status |
| txd | output | 1 | Serial line |
| fill_level | output | CNT_W | Bytes currently queued |
| stat_empty | output | 1 | Queue empty and shifter idle |
| stat_below | output | 1 | Fill below threshold |
| irq | output | 1 | Masked status OR |

## Verification
Two functions can act in the same cycle in this block. The first overlap is the queue clear landing in the same cycle as a write, so the discard and the enqueue collide. The bench drives both strobes in one cycle while five bytes are queued. It then judges that the fill count reads zero and that enabling the sender afterwards produces no start edge. The second overlap is the framer taking a new byte in the very tick its last stop bit ends. The bench provokes this by queueing two characters before enabling, and it judges the exact cycle distance between the two start edges against the frame length computed from the character format and the baud word.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Oversample ticks per bit on the line
    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } fr_state_e;

    // Character format latched at the start of each character
    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } char_fmt_t;

    // Index of the last data bit: codes 0..3 map to 5..8 bits
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return 3'(3'd4 + {1'b0, code});
    endfunction

endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] word,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q >= word);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q >= word) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic accept, take;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign accept  = wr_en && !clr && (count_q != CNT_W'(DEPTH));
    assign take    = rd_en && !clr && (count_q != '0);
    assign rd_data = mem[rd_ptr_q];
    assign empty   = (count_q == '0);
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (take)   rd_ptr_q <= ptr_next(rd_ptr_q);
            case ({accept, take})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import uart_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      tx_en,
    input  char_fmt_t fmt,
    input  logic [7:0] head_data,
    input  logic      fifo_empty,
    output logic      pop,
    output logic      line,
    output logic      idle
);
    fr_state_e        state_q;
    char_fmt_t        fmt_q;
    logic [7:0]       shreg_q;
    logic [OVS_W-1:0] sub_q;
    logic [2:0]       bit_idx_q;
    logic             par_acc_q;
    logic             stop2_q;

    logic at_end, start_ok, frame_done;

    assign at_end     = (sub_q == OVS_W'(OVS - 1));
    assign start_ok   = tx_en && !fifo_empty;
    assign frame_done = (state_q == FS_STOP) && at_end &&
                        (!fmt_q.two_stop || stop2_q);
    assign pop  = tick && start_ok && ((state_q == FS_IDLE) || frame_done);
    assign idle = (state_q == FS_IDLE);

    always_comb begin
        case (state_q)
            FS_START: line = 1'b0;
            FS_DATA:  line = shreg_q[0];
            FS_PAR:   line = par_acc_q ^ fmt_q.par_odd;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FS_IDLE;
            fmt_q     <= '0;
            shreg_q   <= '0;
            sub_q     <= '0;
            bit_idx_q <= '0;
            par_acc_q <= 1'b0;
            stop2_q   <= 1'b0;
        end else if (tick) begin
            if (pop) begin
                state_q   <= FS_START;
                fmt_q     <= fmt;
                shreg_q   <= head_data;
                sub_q     <= '0;
                bit_idx_q <= '0;
                par_acc_q <= 1'b0;
                stop2_q   <= 1'b0;
            end else if (state_q != FS_IDLE) begin
                sub_q <= at_end ? '0 : sub_q + 1'b1;
                if (at_end) begin
                    case (state_q)
                        FS_START: state_q <= FS_DATA;
                        FS_DATA: begin
                            shreg_q   <= {1'b0, shreg_q[7:1]};
                            par_acc_q <= par_acc_q ^ shreg_q[0];
                            if (bit_idx_q == last_bit_idx(fmt_q.len_code)) begin
                                state_q <= fmt_q.par_en ? FS_PAR : FS_STOP;
                            end else begin
                                bit_idx_q <= bit_idx_q + 1'b1;
                            end
                        end
                        FS_PAR: state_q <= FS_STOP;
                        FS_STOP: begin
                            if (fmt_q.two_stop && !stop2_q) begin
                                stop2_q <= 1'b1;
                            end else begin
                                state_q <= FS_IDLE;
                            end
                        end
                        default: state_q <= FS_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             fifo_clr,
    input  logic [1:0]       cfg_char_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic [DIV_W-1:0] cfg_baud_word,
    input  logic             cfg_brg_en,
    input  logic             cfg_tx_en,
    input  logic             cfg_break,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic             irq_en_empty,
    input  logic             irq_en_below,
    output logic             txd,
    output logic [CNT_W-1:0] fill_level,
    output logic             stat_empty,
    output logic             stat_below,
    output logic             irq
);
    logic       tick, pop, line, fr_idle, q_empty;
    logic [7:0] head;
    char_fmt_t  fmt;

    assign fmt = '{len_code: cfg_char_len, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    utx_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_brg_en),
        .word (cfg_baud_word),
        .tick (tick)
    );

    utx_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (q_empty),
        .count   (fill_level)
    );

    utx_framer framer_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_en      (cfg_tx_en),
        .fmt        (fmt),
        .head_data  (head),
        .fifo_empty (q_empty),
        .pop        (pop),
        .line       (line),
        .idle       (fr_idle)
    );

    assign txd        = line && !cfg_break;
    assign stat_empty = q_empty && fr_idle;
    assign stat_below = (fill_level < cfg_thresh);
    assign irq        = (stat_empty && irq_en_empty) || (stat_below && irq_en_below);
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_clr,
    input logic             cfg_break,
    input logic             cfg_tx_en,
    input logic             txd,
    input logic [CNT_W-1:0] fill_level,
    input logic             stat_empty
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !cfg_break) |-> (txd && fill_level == '0 && stat_empty));

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fifo_clr) |-> (int'(fill_level) <= int'($past(fill_level)) + 1));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_level) == CNT_W'(DEPTH) && !$past(fifo_clr))
            |-> (int'(fill_level) >= DEPTH - 1));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (fill_level == '0));

    // R11
    break_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_break |-> !txd);

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_empty && !cfg_break) |-> (txd && fill_level == '0));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_tx_en) && !$past(fifo_clr)) |-> (fill_level >= $past(fill_level)));
endmodule

bind uart_tx_core uart_tx_core_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .fifo_clr   (fifo_clr),
    .cfg_break  (cfg_break),
    .cfg_tx_en  (cfg_tx_en),
    .txd        (txd),
    .fill_level (fill_level),
    .stat_empty (stat_empty)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;
    localparam int DEPTH = 16;
    localparam int DIV_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic fifo_clr = 1'b0;
    logic [1:0] cfg_char_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [DIV_W-1:0] cfg_baud_word = 16'd1;
    logic cfg_brg_en = 1'b1, cfg_tx_en = 1'b0, cfg_break = 1'b0;
    logic [CNT_W-1:0] cfg_thresh = CNT_W'(8);
    logic irq_en_empty = 1'b0, irq_en_below = 1'b0;
    logic txd, stat_empty, stat_below, irq;
    logic [CNT_W-1:0] fill_level;

    int n_tests = 0;
    int n_fail  = 0;
    longint cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_core #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
        .cfg_char_len(cfg_char_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_baud_word(cfg_baud_word), .cfg_brg_en(cfg_brg_en),
        .cfg_tx_en(cfg_tx_en), .cfg_break(cfg_break), .cfg_thresh(cfg_thresh),
        .irq_en_empty(irq_en_empty), .irq_en_below(irq_en_below), .txd(txd),
        .fill_level(fill_level), .stat_empty(stat_empty), .stat_below(stat_below), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Decode one character from the line; returns the start-edge cycle
    task automatic rx_char(input int nb, input bit pen, input bit podd, input bit two,
                           input int w, input logic [7:0] exp, output longint s);
        int bp;
        logic [7:0] got;
        logic [7:0] emask;
        bp = 16 * (w + 1);
        got = '0;
        emask = exp & 8'((1 << nb) - 1);
        while (txd !== 1'b0) @(negedge clk);
        s = cyc;
        repeat (bp / 2) @(negedge clk);
        check(txd == 1'b0, "R4 start bit", txd, 0);
        check(stat_empty == 1'b0, "R8 busy while sending", stat_empty, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (bp) @(negedge clk);
            got[i] = txd;
        end
        check(got == emask, "R4 data bits", got, emask);
        if (pen) begin
            repeat (bp) @(negedge clk);
            check(txd == ((^emask) ^ podd), "R5 parity bit", txd, (^emask) ^ podd);
        end
        for (int j = 0; j < (two ? 2 : 1); j++) begin
            repeat (bp) @(negedge clk);
            check(txd == 1'b1, "R6 stop bit", txd, 1);
        end
    endtask

    task automatic run_frames(input int code, input bit pen, input bit podd, input bit two,
                              input int w, input logic [7:0] b0, input logic [7:0] b1);
        longint s0, s1, flen;
        int nb;
        @(negedge clk);
        cfg_tx_en = 1'b0;
        cfg_char_len = 2'(code); cfg_par_en = pen; cfg_par_odd = podd;
        cfg_two_stop = two; cfg_baud_word = DIV_W'(w);
        push(b0);
        push(b1);
        check(fill_level == 2, "R2 fill after two writes", fill_level, 2);
        @(negedge clk);
        cfg_tx_en = 1'b1;
        nb = 5 + code;
        flen = longint'(1 + nb + (pen ? 1 : 0) + (two ? 2 : 1)) * 16 * (w + 1);
        rx_char(nb, pen, podd, two, w, b0, s0);
        rx_char(nb, pen, podd, two, w, b1, s1);
        check(s1 - s0 == flen, "R6 R7 start spacing", s1 - s0, flen);
        while (!stat_empty) @(negedge clk);
        check(cyc - s1 == flen, "R8 empty after last stop", cyc - s1, flen);
        cfg_tx_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        longint s;
        int bad;
        repeat (3) @(negedge clk);
        #1;
        // R1 during reset
        check(txd == 1'b1, "R1 idle line", txd, 1);
        check(fill_level == 0, "R1 fill zero", fill_level, 0);
        check(stat_empty == 1'b1, "R1 empty", stat_empty, 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && fill_level == 0 && stat_empty, "R1 after reset", txd, 1);

        // R2 R9 R10: fill sweep with sender disabled
        for (int k = 0; k <= DEPTH; k++) begin
            if (k > 0) push(8'(8'h30 + k));
            check(fill_level == CNT_W'(k), "R2 fill count", fill_level, k);
            for (int t = 0; t <= DEPTH; t++) begin
                cfg_thresh = CNT_W'(t);
                #1;
                check(stat_below == (k < t), "R9 below threshold", stat_below, k < t);
            end
            cfg_thresh = CNT_W'(8);
            for (int m = 0; m < 4; m++) begin
                irq_en_empty = m[0]; irq_en_below = m[1];
                #1;
                check(irq == ((m[0] && k == 0) || (m[1] && k < 8)), "R10 irq combine",
                      irq, (m[0] && k == 0) || (m[1] && k < 8));
            end
            irq_en_empty = 1'b0; irq_en_below = 1'b0;
        end
        push(8'hEE);
        check(fill_level == DEPTH, "R2 write into full dropped", fill_level, DEPTH);
        // R2 order: drain 16 bytes at 8N1, word 1
        @(negedge clk);
        cfg_tx_en = 1'b1;
        for (int k = 1; k <= DEPTH; k++) begin
            rx_char(8, 1'b0, 1'b0, 1'b0, 1, 8'(8'h30 + k), s);
        end
        while (!stat_empty) @(negedge clk);
        check(fill_level == 0, "R2 drained", fill_level, 0);
        cfg_tx_en = 1'b0;

        // R3: clear colliding with a write
        for (int k = 0; k < 5; k++) push(8'(k));
        check(fill_level == 5, "R3 preload", fill_level, 5);
        @(negedge clk);
        fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        fifo_clr = 1'b0; wr_en = 1'b0;
        check(fill_level == 0, "R3 clear wins over write", fill_level, 0);
        cfg_tx_en = 1'b1;
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0, "R3 nothing sent after clear", bad, 0);
        cfg_tx_en = 1'b0;

        // R12: transmit enable low holds the queue
        push(8'h11); push(8'h22); push(8'h33);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0 && fill_level == 3, "R12 tx disabled holds", fill_level, 3);
        // R12: baud counter stopped
        cfg_brg_en = 1'b0; cfg_tx_en = 1'b1;
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0 && fill_level == 3, "R12 baud stopped holds", fill_level, 3);
        cfg_brg_en = 1'b1;
        rx_char(8, 1'b0, 1'b0, 1'b0, 1, 8'h11, s);
        rx_char(8, 1'b0, 1'b0, 1'b0, 1, 8'h22, s);
        rx_char(8, 1'b0, 1'b0, 1'b0, 1, 8'h33, s);
        while (!stat_empty) @(negedge clk);
        cfg_tx_en = 1'b0;

        // R11: break while idle and mid-character
        @(negedge clk);
        cfg_break = 1'b1;
        #1;
        check(txd == 1'b0, "R11 break idle", txd, 0);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        check(bad == 0, "R11 break held", bad, 0);
        cfg_break = 1'b0;
        #1;
        check(txd == 1'b1, "R11 break released", txd, 1);
        push(8'hFF);
        @(negedge clk);
        cfg_tx_en = 1'b1;
        while (txd !== 1'b0) @(negedge clk);
        repeat (3 * 32) @(negedge clk);
        cfg_break = 1'b1;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        check(bad == 0, "R11 break mid character", bad, 0);
        cfg_break = 1'b0;
        while (!stat_empty) @(negedge clk);
        #1;
        check(txd == 1'b1, "R11 line after break", txd, 1);
        cfg_tx_en = 1'b0;

        // R7: baud word sweep
        run_frames(3, 1'b0, 1'b0, 1'b0, 0, 8'hC3, 8'h3C);
        run_frames(3, 1'b0, 1'b0, 1'b0, 2, 8'h81, 8'h7E);
        run_frames(3, 1'b1, 1'b1, 1'b1, 5, 8'h96, 8'h01);

        // R4 R5 R6: full format sweep
        for (int code = 0; code < 4; code++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    run_frames(code, pm != 0, pm == 2, two != 0, 1,
                               8'(8'hA5 ^ (code * 37 + pm * 11 + two * 5)),
                               8'(8'h5B + code * 13 + pm * 7 + two));
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule